// File: doc/BRIEF.md
# Tagged Message Receive Matcher

This block holds a small table of messages that have arrived for a process. For each message it stores the sender's process ID, a tag and a handle that points to the payload. A receive request names the sender it expects and a tag. Either field may be replaced by a wildcard. The block finds the earliest stored message that fits the request, returns that message's handle, sender and tag, and deletes the entry in the same cycle. A completed receive is a pairwise synchronisation point between the sending and the receiving process.

Each receive runs in one of two modes. In blocking mode the request stays pending until a fitting message is present. In non-blocking mode the request completes on its first evaluation and reports a miss when nothing fits. Only one receive can be in progress at a time. The table keeps arrival order by compaction: the entry at index 0 is always the oldest. Arriving messages are held off with a ready signal while the table is full.

Top module: `msg_rx_matcher`

## Requirements
- R1: While reset is applied and in the first cycle after it, msg_ready and rcv_ready are 1 and done_vld is 0.
- R2: A receive that is accepted on a clock edge (rcv_req and rcv_ready both 1) is evaluated against the table in the following cycle. When it finds a stored message with an equal source and an equal tag, done_vld and done_hit are 1 for exactly one cycle after the next edge, and done_hdl, done_src and done_tag carry that message.
- R3: When rcv_any_src is 1, a stored message fits the request whatever its source, provided its tag fits.
- R4: When rcv_any_tag is 1, a stored message fits the request whatever its tag, provided its source fits.
- R5: When several stored messages fit a request, the one accepted earliest is delivered.
- R6: A delivered message is removed from the table on the edge that raises done_vld. A later receive can therefore not get the same message again.
- R7: A non-blocking receive (rcv_block = 0) with no fitting message completes one cycle after it is accepted, with done_vld = 1, done_hit = 0 and done_hdl = 0. The table is left unchanged.
- R8: A blocking receive (rcv_block = 1) produces no done_vld while nothing fits. A fitting message accepted on edge E completes the receive on edge E+1.
- R9: When 8 messages are stored, msg_ready is 0. A message offered while msg_ready is 0 is not stored.
- R10: rcv_ready is 0 from the edge that accepts a receive until the edge that completes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_valid | input | 1 | An arriving message is offered |
| msg_ready | output | 1 | The table has a free entry |
| msg_src | input | 4 | Sender process ID of the arriving message |
| msg_tag | input | 8 | Tag of the arriving message |
| msg_hdl | input | 16 | Payload handle of the arriving message |
| rcv_req | input | 1 | A receive is requested |
| rcv_ready | output | 1 | No receive is in progress |
| rcv_block | input | 1 | 1 selects blocking mode, 0 selects non-blocking mode |
| rcv_src | input | 4 | Expected sender |
| rcv_any_src | input | 1 | Any sender fits |
| rcv_tag | input | 8 | Expected tag |
| rcv_any_tag | input | 1 | Any tag fits |
| done_vld | output | 1 | One-cycle receive completion |
| done_hit | output | 1 | The completion delivered a message |
| done_src | output | 4 | Sender of the delivered message |
| done_tag | output | 8 | Tag of the delivered message |
| done_hdl | output | 16 | Handle of the delivered message, 0 on a miss |

## Verification
A receive that is accepted on one edge is evaluated in the next cycle, so its completion appears after the second edge. The bench drives on falling edges and sees that completion on the second falling edge after it raises rcv_req. A message stored on edge E completes a waiting blocking receive after edge E+1. The bench checks explicitly that done_vld is still 0 one falling edge after the store and is 1 one falling edge later. Every expected completion is queued by the driver, and the monitor pops one item each time done_vld is 1. A completion with no queued item, or a queue that is not empty at the end, counts as a failure.

// File: rtl/msgm_pkg.sv
package msgm_pkg;
  parameter int SRC_W = 4;
  parameter int TAG_W = 8;
  parameter int HDL_W = 16;

  typedef struct packed {
    logic [SRC_W-1:0] src;
    logic [TAG_W-1:0] tag;
    logic [HDL_W-1:0] hdl;
  } msg_t;
endpackage

// File: rtl/msgm_table.sv
// Arrival-ordered message store; index 0 is always the oldest entry.
module msgm_table
  import msgm_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  push,
  input  msg_t                  push_msg,
  input  logic                  pop,
  input  logic [IDX_W-1:0]      pop_idx,
  output msg_t [DEPTH-1:0]      ents,
  output logic [CNT_W-1:0]      cnt,
  output logic                  full
);
  msg_t [DEPTH-1:0] ents_q, ents_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, cnt_a;
  logic             ents_en;

  always_comb begin
    ents_n = ents_q;
    cnt_a  = cnt_q;
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IDX_W'(i) >= pop_idx) ents_n[i] = ents_q[i+1];
      end
      cnt_a = cnt_q - CNT_W'(1);
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (push && (CNT_W'(i) == cnt_a)) ents_n[i] = push_msg;
    end
    cnt_n   = cnt_a + CNT_W'(push);
    ents_en = push | pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (ents_en) cnt_q <= cnt_n;
  end

  always_ff @(posedge clk) begin
    if (ents_en) ents_q <= ents_n;
  end

  assign ents = ents_q;
  assign cnt  = cnt_q;
  assign full = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/msgm_match.sv
// Compares every live entry with the request and picks the lowest (oldest) index that fits.
module msgm_match
  import msgm_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  msg_t [DEPTH-1:0]  ents,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [SRC_W-1:0]  want_src,
  input  logic              any_src,
  input  logic [TAG_W-1:0]  want_tag,
  input  logic              any_tag,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  logic [DEPTH-1:0] fit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic live, src_ok, tag_ok;
    assign live   = (CNT_W'(g) < cnt);
    assign src_ok = any_src | (ents[g].src == want_src);
    assign tag_ok = any_tag | (ents[g].tag == want_tag);
    assign fit[g] = live & src_ok & tag_ok;
  end

  always_comb begin
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (fit[i]) idx = IDX_W'(i);
    end
    hit = |fit;
  end
endmodule

// File: rtl/msg_rx_matcher.sv
module msg_rx_matcher
  import msgm_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  output logic             msg_ready,
  input  logic [SRC_W-1:0] msg_src,
  input  logic [TAG_W-1:0] msg_tag,
  input  logic [HDL_W-1:0] msg_hdl,
  input  logic             rcv_req,
  output logic             rcv_ready,
  input  logic             rcv_block,
  input  logic [SRC_W-1:0] rcv_src,
  input  logic             rcv_any_src,
  input  logic [TAG_W-1:0] rcv_tag,
  input  logic             rcv_any_tag,
  output logic             done_vld,
  output logic             done_hit,
  output logic [SRC_W-1:0] done_src,
  output logic [TAG_W-1:0] done_tag,
  output logic [HDL_W-1:0] done_hdl
);
  msg_t [DEPTH-1:0] ents;
  logic [CNT_W-1:0] cnt;
  logic             full;
  logic             push, pop;
  msg_t             in_msg;

  // pending receive
  logic             pend_vld_q, pend_vld_n;
  logic             pend_blk_q;
  logic [SRC_W-1:0] pend_src_q;
  logic             pend_any_src_q;
  logic [TAG_W-1:0] pend_tag_q;
  logic             pend_any_tag_q;
  logic             accept, finish;

  logic             m_hit;
  logic [IDX_W-1:0] m_idx;
  msg_t             sel;

  logic             done_vld_n, done_hit_n;
  msg_t             done_msg_q, done_msg_n;

  assign in_msg = '{src: msg_src, tag: msg_tag, hdl: msg_hdl};
  assign push   = msg_valid & ~full;

  msgm_table #(.DEPTH(DEPTH)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_msg (in_msg),
    .pop      (pop),
    .pop_idx  (m_idx),
    .ents     (ents),
    .cnt      (cnt),
    .full     (full)
  );

  msgm_match #(.DEPTH(DEPTH)) u_match (
    .ents     (ents),
    .cnt      (cnt),
    .want_src (pend_src_q),
    .any_src  (pend_any_src_q),
    .want_tag (pend_tag_q),
    .any_tag  (pend_any_tag_q),
    .hit      (m_hit),
    .idx      (m_idx)
  );

  always_comb begin
    accept     = rcv_req & ~pend_vld_q;
    finish     = pend_vld_q & (m_hit | ~pend_blk_q);
    pop        = finish & m_hit;
    sel        = ents[m_idx];
    pend_vld_n = pend_vld_q;
    if (accept)      pend_vld_n = 1'b1;
    else if (finish) pend_vld_n = 1'b0;
    done_vld_n = finish;
    done_hit_n = pop;
    done_msg_n = pop ? sel : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld_q <= 1'b0;
      done_vld   <= 1'b0;
      done_hit   <= 1'b0;
    end else begin
      pend_vld_q <= pend_vld_n;
      done_vld   <= done_vld_n;
      done_hit   <= done_hit_n;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      pend_blk_q     <= rcv_block;
      pend_src_q     <= rcv_src;
      pend_any_src_q <= rcv_any_src;
      pend_tag_q     <= rcv_tag;
      pend_any_tag_q <= rcv_any_tag;
    end
    if (finish) done_msg_q <= done_msg_n;
  end

  assign msg_ready = ~full;
  assign rcv_ready = ~pend_vld_q;
  assign done_src  = done_msg_q.src;
  assign done_tag  = done_msg_q.tag;
  assign done_hdl  = done_msg_q.hdl;
endmodule

// File: rtl/msgm_chk.sv
module msgm_chk #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic             rcv_req,
  input logic             rcv_ready,
  input logic             done_vld,
  input logic             done_hit,
  input logic             pend_blk,
  input logic [CNT_W-1:0] cnt
);
  // R10
  req_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rcv_req && rcv_ready) |=> !rcv_ready);

  // R8
  blk_nomiss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vld && !done_hit) |-> $past(!pend_blk));

  // R6
  pop_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vld && done_hit) |->
      (int'(cnt) == int'($past(cnt)) - 1 + int'($past(msg_valid && msg_ready))));

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_ready |=> (int'(cnt) <= int'($past(cnt))));

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld |=> !done_vld);
endmodule

bind msg_rx_matcher msgm_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .rcv_req   (rcv_req),
  .rcv_ready (rcv_ready),
  .done_vld  (done_vld),
  .done_hit  (done_hit),
  .pend_blk  (pend_blk_q),
  .cnt       (cnt)
);

// File: tb/tb_msg_rx_matcher.sv
module tb_msg_rx_matcher;
  logic        clk, rst_n;
  logic        msg_valid, msg_ready;
  logic [3:0]  msg_src;
  logic [7:0]  msg_tag;
  logic [15:0] msg_hdl;
  logic        rcv_req, rcv_ready, rcv_block, rcv_any_src, rcv_any_tag;
  logic [3:0]  rcv_src;
  logic [7:0]  rcv_tag;
  logic        done_vld, done_hit;
  logic [3:0]  done_src;
  logic [7:0]  done_tag;
  logic [15:0] done_hdl;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic        hit;
    logic [15:0] hdl;
    string       req;
  } exp_t;
  exp_t sbq[$];

  msg_rx_matcher dut (
    .clk(clk), .rst_n(rst_n),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_src(msg_src), .msg_tag(msg_tag), .msg_hdl(msg_hdl),
    .rcv_req(rcv_req), .rcv_ready(rcv_ready), .rcv_block(rcv_block),
    .rcv_src(rcv_src), .rcv_any_src(rcv_any_src),
    .rcv_tag(rcv_tag), .rcv_any_tag(rcv_any_tag),
    .done_vld(done_vld), .done_hit(done_hit),
    .done_src(done_src), .done_tag(done_tag), .done_hdl(done_hdl)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: one queued item per completion
  always @(negedge clk) begin
    if (rst_n && done_vld) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R2 unexpected completion", int'(done_hdl), -1);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(done_hit == e.hit, {e.req, " hit"}, int'(done_hit), int'(e.hit));
        chk(done_hdl == e.hdl, {e.req, " handle"}, int'(done_hdl), int'(e.hdl));
      end
    end
  end

  task automatic send(input logic [3:0] s, input logic [7:0] t, input logic [15:0] h);
    while (!msg_ready) @(negedge clk);
    msg_valid = 1'b1; msg_src = s; msg_tag = t; msg_hdl = h;
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic recv(input logic blk, input logic [3:0] s, input logic as,
                      input logic [7:0] t, input logic at,
                      input logic eh, input logic [15:0] ehdl,
                      input string req, input logic wait_done);
    exp_t e;
    e.hit = eh; e.hdl = eh ? ehdl : 16'd0; e.req = req;
    sbq.push_back(e);
    while (!rcv_ready) @(negedge clk);
    rcv_req = 1'b1; rcv_block = blk; rcv_src = s; rcv_any_src = as;
    rcv_tag = t; rcv_any_tag = at;
    @(negedge clk);
    rcv_req = 1'b0;
    if (wait_done) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; msg_valid = 1'b0; msg_src = '0; msg_tag = '0; msg_hdl = '0;
    rcv_req = 1'b0; rcv_block = 1'b0; rcv_src = '0; rcv_any_src = 1'b0;
    rcv_tag = '0; rcv_any_tag = 1'b0;
    repeat (3) @(negedge clk);
    chk(msg_ready == 1'b1, "R1 msg_ready in reset", int'(msg_ready), 1);
    chk(rcv_ready == 1'b1, "R1 rcv_ready in reset", int'(rcv_ready), 1);
    chk(done_vld == 1'b0, "R1 done_vld in reset", int'(done_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(msg_ready && rcv_ready && !done_vld, "R1 after release",
        int'({msg_ready, rcv_ready, done_vld}), 6);

    // R2 exact match, then R6 the entry is gone
    send(4'd1, 8'd5, 16'd100);
    recv(1'b0, 4'd1, 1'b0, 8'd5, 1'b0, 1'b1, 16'd100, "R2 exact", 1'b1);
    recv(1'b0, 4'd1, 1'b0, 8'd5, 1'b0, 1'b0, 16'd0, "R6 consumed", 1'b1);

    // R7 misses leave the table unchanged
    send(4'd2, 8'd7, 16'd200);
    recv(1'b0, 4'd2, 1'b0, 8'd8, 1'b0, 1'b0, 16'd0, "R7 tag differs", 1'b1);
    recv(1'b0, 4'd3, 1'b0, 8'd7, 1'b0, 1'b0, 16'd0, "R7 src differs", 1'b1);
    recv(1'b0, 4'd2, 1'b0, 8'd7, 1'b0, 1'b1, 16'd200, "R7 table intact", 1'b1);

    // R3 any source
    send(4'd4, 8'd9, 16'd300);
    recv(1'b0, 4'd0, 1'b1, 8'd9, 1'b0, 1'b1, 16'd300, "R3 any source", 1'b1);

    // R4 any tag picks by source
    send(4'd5, 8'd1, 16'd401);
    send(4'd6, 8'd2, 16'd402);
    recv(1'b0, 4'd6, 1'b0, 8'd0, 1'b1, 1'b1, 16'd402, "R4 any tag src6", 1'b1);
    recv(1'b0, 4'd5, 1'b0, 8'd0, 1'b1, 1'b1, 16'd401, "R4 any tag src5", 1'b1);

    // R5 oldest first
    send(4'd7, 8'd3, 16'd501);
    send(4'd7, 8'd3, 16'd502);
    send(4'd7, 8'd3, 16'd503);
    recv(1'b0, 4'd7, 1'b0, 8'd3, 1'b0, 1'b1, 16'd501, "R5 oldest 1", 1'b1);
    recv(1'b0, 4'd7, 1'b0, 8'd3, 1'b0, 1'b1, 16'd502, "R5 oldest 2", 1'b1);
    recv(1'b0, 4'd7, 1'b0, 8'd3, 1'b0, 1'b1, 16'd503, "R5 oldest 3", 1'b1);
    send(4'd1, 8'd1, 16'd511);
    send(4'd2, 8'd2, 16'd512);
    recv(1'b0, 4'd0, 1'b1, 8'd0, 1'b1, 1'b1, 16'd511, "R5 full wildcard 1", 1'b1);
    recv(1'b0, 4'd0, 1'b1, 8'd0, 1'b1, 1'b1, 16'd512, "R5 full wildcard 2", 1'b1);

    // R8 blocking wait, R10 no new receive while waiting
    recv(1'b1, 4'd8, 1'b0, 8'd4, 1'b0, 1'b1, 16'd600, "R8 blocking", 1'b0);
    for (int k = 0; k < 5; k++) begin
      chk(rcv_ready == 1'b0, "R10 busy while waiting", int'(rcv_ready), 0);
      chk(done_vld == 1'b0, "R8 no completion yet", int'(done_vld), 0);
      @(negedge clk);
    end
    send(4'd8, 8'd4, 16'd600);
    chk(done_vld == 1'b0, "R8 one edge after store", int'(done_vld), 0);
    @(negedge clk);
    chk(done_vld == 1'b1, "R8 two edges after store", int'(done_vld), 1);
    chk(rcv_ready == 1'b1, "R10 free after completion", int'(rcv_ready), 1);
    send(4'd8, 8'd5, 16'd610);
    recv(1'b1, 4'd8, 1'b0, 8'd5, 1'b0, 1'b1, 16'd610, "R8 blocking present", 1'b1);

    // R9 full table
    for (int k = 0; k < 8; k++) send(4'd9, 8'(k), 16'(700 + k));
    chk(msg_ready == 1'b0, "R9 full", int'(msg_ready), 0);
    msg_valid = 1'b1; msg_src = 4'd9; msg_tag = 8'd15; msg_hdl = 16'd799;
    repeat (2) @(negedge clk);
    chk(msg_ready == 1'b0, "R9 still full", int'(msg_ready), 0);
    msg_valid = 1'b0;
    recv(1'b0, 4'd9, 1'b0, 8'd0, 1'b1, 1'b1, 16'd700, "R9 drain 0", 1'b1);
    chk(msg_ready == 1'b1, "R9 ready after pop", int'(msg_ready), 1);
    for (int k = 1; k < 8; k++)
      recv(1'b0, 4'd9, 1'b0, 8'd0, 1'b1, 1'b1, 16'(700 + k), "R9 drain", 1'b1);
    recv(1'b0, 4'd9, 1'b0, 8'd0, 1'b1, 1'b0, 16'd0, "R9 rejected not stored", 1'b1);

    repeat (3) @(negedge clk);
    chk(sbq.size() == 0, "R2 all completions seen", sbq.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule